// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Address Decoder

This block connects an 8-bit processor whose low address byte shares its pins with the data byte to the memories and I/O devices around it. While the address-latch strobe is high, the shared byte passes straight through to the address and is also held. When the strobe falls, the held byte is combined with the dedicated upper address byte to form a stable 16-bit address. From then on the shared lines carry data only.

A single memory-or-I/O select line is combined with the processor's active-low read and write strobes. The result is four active-low command strobes: memory read, memory write, I/O read and I/O write. The address is decoded into selects for a ROM window, a RAM window, one input port and one output port. The port selects use an 8-bit port number and apply only in I/O cycles. A read multiplexer returns data toward the processor only when a device that can answer is read. An internal register holds the output port value. It takes the bus data when an I/O write to its port ends.

Top module: `bus_demux_decoder`

## Requirements
- R1: While rst_n is low, and right after it is released with ale low, the held address byte is 00h, out_port is 00h and all four command strobes are high.
- R2: While ale is high, addr[7:0] follows ad_in. After ale goes low, addr[7:0] keeps the last value seen while ale was high, whatever ad_in does.
- R3: addr[15:8] always equals addr_hi, so addr = {addr_hi, held low byte}.
- R4: With io_m = 0 a read gives mem_rd_n = 0 and a write gives mem_wr_n = 0. With io_m = 1 they give io_rd_n = 0 and io_wr_n = 0. A strobe is asserted only when exactly one of rd_n or wr_n is low, so no more than one strobe is low at any time.
- R5: While ale is high, all four command strobes stay high.
- R6: With io_m = 0, rom_sel is 1 for addresses 0000h–1FFFh and ram_sel is 1 for 8000h–FFFFh. Between them neither is set, and with io_m = 1 both are 0.
- R7: With io_m = 1, the port number is addr[7:0]. Port 00h sets in_sel and port 01h sets out_sel. Both are 0 for any other port and whenever io_m = 0.
- R8: ad_oe is 1 only during a memory read with rom_sel or ram_sel set, or an I/O read with in_sel set. ad_out then carries rom_rdata, ram_rdata or in_port_data for that device, and is 00h otherwise.
- R9: wdata_en is 1 exactly while mem_wr_n or io_wr_n is low, and wdata equals ad_in.
- R10: out_port loads the ad_in value sampled on the last clock edge of an I/O write to port 01h. The update appears on the first clock edge after io_wr_n returns high. Writes to any other port, or memory writes, leave out_port unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address-latch strobe, active high |
| io_m | input | 1 | 0 = memory cycle, 1 = I/O cycle |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| addr_hi | input | 8 | Dedicated upper address byte |
| ad_in | input | 8 | Shared address/data byte from the processor |
| ad_out | output | 8 | Read data toward the processor |
| ad_oe | output | 1 | Drive enable for ad_out onto the shared lines |
| addr | output | 16 | Demultiplexed address |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| rom_sel | output | 1 | ROM window select |
| ram_sel | output | 1 | RAM window select |
| in_sel | output | 1 | Input port select |
| out_sel | output | 1 | Output port select |
| rom_rdata | input | 8 | Data returned by the ROM |
| ram_rdata | input | 8 | Data returned by the RAM |
| in_port_data | input | 8 | Value presented by the input port |
| wdata | output | 8 | Write data toward devices |
| wdata_en | output | 1 | Write buffer enable toward devices |
| out_port | output | 8 | Output port register |

## Verification
The checker assumes the processor drives well-formed bus cycles. Each cycle has an address phase with ale high and the read and write strobes high, then a data phase with ale low, and io_m and addr_hi stay steady until the strobe is released. The output-port property also assumes that at least one clock edge passes with io_wr_n low before the port register can change. The directed tasks change inputs only on falling clock edges, always open a cycle with an address phase, and hold each strobe low across at least one rising edge. The read-and-write-together case and the strobe-during-ale case are the only deliberate departures. Both are used to show that the strobe outputs stay quiet.

// File: rtl/bdd_pkg.sv
package bdd_pkg;
   typedef struct packed {
      logic mem_rd;
      logic mem_wr;
      logic io_rd;
      logic io_wr;
   } cmd_t;

   typedef struct packed {
      logic rom;
      logic ram;
      logic inp;
      logic outp;
   } sel_t;
endpackage

// File: rtl/bdd_addr_latch.sv
module bdd_addr_latch #(
   parameter int unsigned LO_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ale,
   input  logic [LO_W-1:0] ad_in,
   output logic [LO_W-1:0] lo_addr
);
   logic [LO_W-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   held_q <= '0;
      else if (ale) held_q <= ad_in;
   end

   // transparent while the strobe is high, held value afterwards
   assign lo_addr = ale ? ad_in : held_q;
endmodule

// File: rtl/bdd_cmd_gen.sv
module bdd_cmd_gen
   import bdd_pkg::*;
(
   input  logic ale,
   input  logic io_m,
   input  logic rd_n,
   input  logic wr_n,
   output cmd_t cmd
);
   logic rd_only, wr_only, live;

   assign live    = !ale;
   assign rd_only = !rd_n &  wr_n;
   assign wr_only =  rd_n & !wr_n;

   always_comb begin
      cmd.mem_rd = live & !io_m & rd_only;
      cmd.mem_wr = live & !io_m & wr_only;
      cmd.io_rd  = live &  io_m & rd_only;
      cmd.io_wr  = live &  io_m & wr_only;
   end
endmodule

// File: rtl/bdd_addr_decode.sv
module bdd_addr_decode
   import bdd_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned PORT_W       = 8,
   parameter int unsigned ROM_FIRST    = 'h0000,
   parameter int unsigned ROM_LAST     = 'h1FFF,
   parameter int unsigned RAM_FIRST    = 'h8000,
   parameter int unsigned RAM_LAST     = 'hFFFF,
   parameter int unsigned IN_PORT      = 'h00,
   parameter int unsigned OUT_PORT     = 'h01,
   parameter bit          PORT_FROM_HI = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              io_m,
   output sel_t              sel
);
   localparam logic [ADDR_W-1:0] ROM_BASE = ADDR_W'(ROM_FIRST);
   localparam logic [ADDR_W-1:0] ROM_SPAN = ADDR_W'(ROM_LAST - ROM_FIRST);
   localparam logic [ADDR_W-1:0] RAM_BASE = ADDR_W'(RAM_FIRST);
   localparam logic [ADDR_W-1:0] RAM_SPAN = ADDR_W'(RAM_LAST - RAM_FIRST);
   localparam logic [PORT_W-1:0] IN_NUM   = PORT_W'(IN_PORT);
   localparam logic [PORT_W-1:0] OUT_NUM  = PORT_W'(OUT_PORT);

   logic [PORT_W-1:0] port_num;
   logic [ADDR_W-1:0] rom_off, ram_off;

   generate
      if (PORT_FROM_HI) begin : g_port_hi
         assign port_num = addr[ADDR_W-1 -: PORT_W];
      end else begin : g_port_lo
         assign port_num = addr[PORT_W-1:0];
      end
   endgenerate

   // offset compare keeps each window check to one subtract and one compare
   assign rom_off = addr - ROM_BASE;
   assign ram_off = addr - RAM_BASE;

   always_comb begin
      sel.rom  = !io_m & (rom_off <= ROM_SPAN);
      sel.ram  = !io_m & (ram_off <= RAM_SPAN);
      sel.inp  =  io_m & (port_num == IN_NUM);
      sel.outp =  io_m & (port_num == OUT_NUM);
   end
endmodule

// File: rtl/bdd_data_steer.sv
module bdd_data_steer
   import bdd_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_t              cmd,
   input  sel_t              sel,
   input  logic [DATA_W-1:0] ad_in,
   input  logic [DATA_W-1:0] rom_rdata,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic [DATA_W-1:0] in_port_data,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [DATA_W-1:0] wdata,
   output logic              wdata_en,
   output logic [DATA_W-1:0] out_port
);
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] port_q, stage_q;
   logic              wr_open_q;

   always_comb begin
      if (sel.rom)      rd_mux = rom_rdata;
      else if (sel.ram) rd_mux = ram_rdata;
      else if (sel.inp) rd_mux = in_port_data;
      else              rd_mux = '0;
   end

   assign ad_oe    = (cmd.mem_rd & (sel.rom | sel.ram)) | (cmd.io_rd & sel.inp);
   assign ad_out   = ad_oe ? rd_mux : '0;
   assign wdata    = ad_in;
   assign wdata_en = cmd.mem_wr | cmd.io_wr;

   // stage data while the port write is open, commit on its release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_q    <= '0;
         stage_q   <= '0;
         wr_open_q <= 1'b0;
      end else begin
         wr_open_q <= cmd.io_wr & sel.outp;
         if (cmd.io_wr & sel.outp) stage_q <= ad_in;
         if (wr_open_q & !cmd.io_wr) port_q <= stage_q;
      end
   end

   assign out_port = port_q;
endmodule

// File: rtl/bus_demux_decoder.sv
module bus_demux_decoder
   import bdd_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned PORT_W       = 8,
   parameter int unsigned ROM_FIRST    = 'h0000,
   parameter int unsigned ROM_LAST     = 'h1FFF,
   parameter int unsigned RAM_FIRST    = 'h8000,
   parameter int unsigned RAM_LAST     = 'hFFFF,
   parameter int unsigned IN_PORT      = 'h00,
   parameter int unsigned OUT_PORT     = 'h01,
   parameter bit          PORT_FROM_HI = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ale,
   input  logic                     io_m,
   input  logic                     rd_n,
   input  logic                     wr_n,
   input  logic [ADDR_W-DATA_W-1:0] addr_hi,
   input  logic [DATA_W-1:0]        ad_in,
   output logic [DATA_W-1:0]        ad_out,
   output logic                     ad_oe,
   output logic [ADDR_W-1:0]        addr,
   output logic                     mem_rd_n,
   output logic                     mem_wr_n,
   output logic                     io_rd_n,
   output logic                     io_wr_n,
   output logic                     rom_sel,
   output logic                     ram_sel,
   output logic                     in_sel,
   output logic                     out_sel,
   input  logic [DATA_W-1:0]        rom_rdata,
   input  logic [DATA_W-1:0]        ram_rdata,
   input  logic [DATA_W-1:0]        in_port_data,
   output logic [DATA_W-1:0]        wdata,
   output logic                     wdata_en,
   output logic [DATA_W-1:0]        out_port
);
   generate
      if (ADDR_W <= DATA_W) begin : g_bad_width
         $error("ADDR_W must exceed DATA_W");
      end
      if (PORT_W > ADDR_W - DATA_W && PORT_FROM_HI) begin : g_bad_port_hi
         $error("PORT_W wider than upper address byte");
      end
      if (PORT_W > DATA_W && !PORT_FROM_HI) begin : g_bad_port_lo
         $error("PORT_W wider than shared byte");
      end
      if (ROM_LAST < ROM_FIRST || RAM_LAST < RAM_FIRST) begin : g_bad_window
         $error("address window ends before it starts");
      end
   endgenerate

   logic [DATA_W-1:0] lo_addr;
   cmd_t              cmd;
   sel_t              sel;

   bdd_addr_latch #(.LO_W(DATA_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .lo_addr(lo_addr)
   );

   assign addr = {addr_hi, lo_addr};

   bdd_cmd_gen u_cmd (
      .ale(ale), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n), .cmd(cmd)
   );

   bdd_addr_decode #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W),
      .ROM_FIRST(ROM_FIRST), .ROM_LAST(ROM_LAST),
      .RAM_FIRST(RAM_FIRST), .RAM_LAST(RAM_LAST),
      .IN_PORT(IN_PORT), .OUT_PORT(OUT_PORT), .PORT_FROM_HI(PORT_FROM_HI)
   ) u_dec (
      .addr(addr), .io_m(io_m), .sel(sel)
   );

   bdd_data_steer #(.DATA_W(DATA_W)) u_steer (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .sel(sel), .ad_in(ad_in),
      .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .in_port_data(in_port_data),
      .ad_out(ad_out), .ad_oe(ad_oe), .wdata(wdata), .wdata_en(wdata_en),
      .out_port(out_port)
   );

   assign mem_rd_n = ~cmd.mem_rd;
   assign mem_wr_n = ~cmd.mem_wr;
   assign io_rd_n  = ~cmd.io_rd;
   assign io_wr_n  = ~cmd.io_wr;
   assign rom_sel  = sel.rom;
   assign ram_sel  = sel.ram;
   assign in_sel   = sel.inp;
   assign out_sel  = sel.outp;
endmodule

// File: rtl/bdd_checker.sv
module bdd_checker #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ale,
   input logic              rd_n,
   input logic              wr_n,
   input logic [ADDR_W-1:0] addr,
   input logic              mem_rd_n,
   input logic              mem_wr_n,
   input logic              io_rd_n,
   input logic              io_wr_n,
   input logic              rom_sel,
   input logic              ram_sel,
   input logic              in_sel,
   input logic              out_sel,
   input logic              ad_oe,
   input logic [DATA_W-1:0] out_port
);
   a_r2_hold_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
      !ale |=> (ale || $stable(addr[DATA_W-1:0])));

   a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}) >= 3);

   a_r5_quiet_in_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n));

   a_r6_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rom_sel, ram_sel, in_sel, out_sel}));

   a_r8_drive_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> (!rd_n && wr_n && !ale));

   a_r10_port_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_port) |-> ($past(io_wr_n, 2) == 1'b0));
endmodule

bind bus_demux_decoder bdd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
   .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
   .rom_sel(rom_sel), .ram_sel(ram_sel), .in_sel(in_sel), .out_sel(out_sel),
   .ad_oe(ad_oe), .out_port(out_port)
);

// File: tb/tb_bus_demux_decoder.sv
module tb_bus_demux_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ale = 1'b0, io_m = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
   logic [7:0]  addr_hi = 8'h00, ad_in = 8'h00;
   logic [7:0]  rom_rdata = 8'hA5, ram_rdata = 8'hC3, in_port_data = 8'h3C;
   logic [7:0]  ad_out, wdata, out_port;
   logic [15:0] addr;
   logic        ad_oe, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
   logic        rom_sel, ram_sel, in_sel, out_sel, wdata_en;
   int          total = 0, fails = 0;

   always #10 clk = ~clk;

   bus_demux_decoder dut (
      .clk(clk), .rst_n(rst_n), .ale(ale), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
      .addr_hi(addr_hi), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .addr(addr),
      .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
      .rom_sel(rom_sel), .ram_sel(ram_sel), .in_sel(in_sel), .out_sel(out_sel),
      .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .in_port_data(in_port_data),
      .wdata(wdata), .wdata_en(wdata_en), .out_port(out_port)
   );

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] strobes();
      return {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};
   endfunction

   task automatic addr_phase(input logic io, input logic [15:0] a);
      @(negedge clk);
      ale = 1'b1; io_m = io; rd_n = 1'b1; wr_n = 1'b1;
      addr_hi = a[15:8]; ad_in = a[7:0];
      @(negedge clk);
      ale = 1'b0; ad_in = 8'hEE;
   endtask

   task automatic end_cycle();
      @(negedge clk);
      rd_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic t_reset();
      #5;
      chk("R1", "addr in reset", addr, 16'h0000);
      chk("R1", "strobes in reset", {12'd0, strobes()}, 16'hF);
      chk("R1", "out_port in reset", {8'd0, out_port}, 16'h0000);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); #5;
      chk("R1", "addr after reset", addr, 16'h0000);
      chk("R1", "out_port after reset", {8'd0, out_port}, 16'h0000);
   endtask

   task automatic t_latch();
      @(negedge clk);
      ale = 1'b1; io_m = 1'b0; addr_hi = 8'h12; ad_in = 8'h34; rd_n = 1'b0;
      #5;
      chk("R2", "transparent", addr, 16'h1234);
      chk("R5", "strobes during ale", {12'd0, strobes()}, 16'hF);
      ad_in = 8'h56; #2;
      chk("R2", "follows while high", addr, 16'h1256);
      @(negedge clk);
      ale = 1'b0; rd_n = 1'b1; ad_in = 8'h99; #5;
      chk("R2", "held after fall", addr, 16'h1256);
      addr_hi = 8'hAB; #2;
      chk("R3", "upper byte direct", addr, 16'hAB56);
   endtask

   task automatic t_mem_read(input logic [15:0] a, input logic er, input logic eam);
      addr_phase(1'b0, a);
      rd_n = 1'b0; #5;
      chk("R4", "mem read strobes", {12'd0, strobes()}, 16'h7);
      chk("R6", "rom_sel", {15'd0, rom_sel}, {15'd0, er});
      chk("R6", "ram_sel", {15'd0, ram_sel}, {15'd0, eam});
      chk("R8", "ad_oe", {15'd0, ad_oe}, {15'd0, er | eam});
      chk("R8", "ad_out", {8'd0, ad_out}, er ? 16'h00A5 : (eam ? 16'h00C3 : 16'h0000));
      end_cycle();
   endtask

   task automatic t_mem_write();
      addr_phase(1'b0, 16'h8010);
      wr_n = 1'b0; ad_in = 8'h77; #5;
      chk("R4", "mem write strobes", {12'd0, strobes()}, 16'hB);
      chk("R8", "no drive on write", {15'd0, ad_oe}, 16'h0);
      chk("R9", "wdata_en", {15'd0, wdata_en}, 16'h1);
      chk("R9", "wdata", {8'd0, wdata}, 16'h0077);
      end_cycle(); #5;
      chk("R9", "wdata_en idle", {15'd0, wdata_en}, 16'h0);
      chk("R10", "mem write leaves port", {8'd0, out_port}, 16'h0000);
   endtask

   task automatic t_io_read();
      addr_phase(1'b1, 16'h0000);
      rd_n = 1'b0; #5;
      chk("R4", "io read strobes", {12'd0, strobes()}, 16'hD);
      chk("R7", "in_sel", {15'd0, in_sel}, 16'h1);
      chk("R6", "rom_sel off in io", {15'd0, rom_sel}, 16'h0);
      chk("R8", "io read data", {8'd0, ad_out}, 16'h003C);
      end_cycle();
      addr_phase(1'b1, 16'h0101);
      rd_n = 1'b0; #5;
      chk("R7", "out_sel", {15'd0, out_sel}, 16'h1);
      chk("R8", "no drive reading out port", {15'd0, ad_oe}, 16'h0);
      end_cycle();
      addr_phase(1'b0, 16'h0001);
      #5;
      chk("R7", "out_sel off in mem", {15'd0, out_sel}, 16'h0);
   endtask

   task automatic t_io_write();
      addr_phase(1'b1, 16'h0101);
      wr_n = 1'b0; ad_in = 8'h5A; #5;
      chk("R4", "io write strobes", {12'd0, strobes()}, 16'hE);
      chk("R9", "io wdata_en", {15'd0, wdata_en}, 16'h1);
      @(negedge clk); #2;
      chk("R10", "port before release", {8'd0, out_port}, 16'h0000);
      wr_n = 1'b1; ad_in = 8'hEE;
      @(negedge clk); #5;
      chk("R10", "port after release", {8'd0, out_port}, 16'h005A);
      addr_phase(1'b1, 16'h0202);
      wr_n = 1'b0; ad_in = 8'h11; #5;
      chk("R7", "port 02 not decoded", {14'd0, in_sel, out_sel}, 16'h0);
      end_cycle();
      @(negedge clk); #5;
      chk("R10", "other port ignored", {8'd0, out_port}, 16'h005A);
   endtask

   task automatic t_both_low();
      addr_phase(1'b0, 16'h0100);
      rd_n = 1'b0; wr_n = 1'b0; #5;
      chk("R4", "rd and wr together", {12'd0, strobes()}, 16'hF);
      chk("R8", "no drive when both", {15'd0, ad_oe}, 16'h0);
      end_cycle();
   endtask

   initial begin
      t_reset();
      t_latch();
      t_mem_read(16'h0000, 1'b1, 1'b0);
      t_mem_read(16'h1FFF, 1'b1, 1'b0);
      t_mem_read(16'h2000, 1'b0, 1'b0);
      t_mem_read(16'h7FFF, 1'b0, 1'b0);
      t_mem_read(16'h8000, 1'b0, 1'b1);
      t_mem_read(16'hFFFF, 1'b0, 1'b1);
      t_mem_write();
      t_io_read();
      t_io_write();
      t_both_low();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(20 * 100000);
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule